// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gating Controller

This controller sits between a host and up to four low-power SRAM banks. In normal operation it routes the host's active-low chip enable to exactly one of four active-low bank enables, chosen by a bank select. A comparator outside the block raises an asynchronous power-fail flag when the supply degrades. Two flops synchronise that flag, and the controller then write-protects every bank.

The banks are not cut off mid-cycle. An access that is already running when the fail takes effect may finish on the bank it started on. If the host does not end it within a bounded number of cycles, all enables are forced high anyway. Once the flag clears, every enable stays high for a fixed stabilisation window before pass-through resumes. A reset enters that same window. Any access that begins while the banks are protected is never passed on. Pass-through only returns after the host enable has been seen idle during normal operation.

Top module: `pfce_gate_ctrl`

## Requirements
- R1: From the first clock edge after reset is released, all four enables stay high (1) for TCER rising edges, whatever the host enable and bank select do.
- R2: In normal operation the enable at index bank_sel (0..3) equals host_ce_n and the other three are high. At no time is more than one enable low.
- R3: The power-fail flag is synchronised by two flops. A flag raised before clock edge 1 changes the controller's state at edge 3. If no access is running, all enables are high from edge 3 on.
- R4: If host_ce_n is low (an access in progress) when the fail takes effect, the bank selected at that edge keeps following host_ce_n, even if bank_sel changes. All enables go high as soon as host_ce_n goes high.
- R5: An access held past the fail is passed for at most TWPT rising edges (counted from the edge at which the fail took effect). From the next edge on, all enables are high.
- R6: After the synchronised flag clears, all enables stay high for TCER further edges. If the flag returns during that window, the window starts again in full once the flag clears.
- R7: An access that begins while the banks are protected or recovering is never passed. After recovery, pass-through resumes only after a rising edge has sampled host_ce_n high in normal operation.
- R8: While the synchronised flag is high and no access is draining, all enables are high regardless of host_ce_n and bank_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail_a | input | 1 | Asynchronous power-fail flag, high while the supply is out of tolerance |
| host_ce_n | input | 1 | Host chip enable, active low |
| bank_sel | input | 2 | Index of the bank that follows the host enable |
| ce_n_out | output | 4 | Conditioned bank enables, active low |

## Verification
The assertions assume that host_ce_n and bank_sel are synchronous to clk and settle well before each rising edge. Only pwr_fail_a may change at an arbitrary time. The bench drives every input on the falling edge. It keeps pwr_fail_a quiet long enough for each phase to settle before the next toggle. The counter-based checks also assume that the fail flag stays low for at least the reset-to-normal window before a drain is provoked, and every scenario restores armed normal operation before it starts.

// File: rtl/pfce_pkg.sv
`timescale 1ns/1ps
package pfce_pkg;

    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROTECT = 2'd2,
        ST_RECOVER = 2'd3
    } pfce_state_e;

    typedef struct packed {
        pfce_state_e        st;
        logic               armed;
        logic [BANK_W-1:0]  bank;
    } pfce_ctl_t;

    function automatic int cnt_width(input int a, input int b);
        return $clog2(((a > b) ? a : b) + 1);
    endfunction

endpackage

// File: rtl/pfce_sync.sv
`timescale 1ns/1ps
module pfce_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pfce_cyc_cnt.sv
`timescale 1ns/1ps
module pfce_cyc_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pfce_ce_decode.sv
`timescale 1ns/1ps
module pfce_ce_decode
    import pfce_pkg::*;
(
    input  logic              pass_en,
    input  logic [BANK_W-1:0] bank,
    input  logic              host_ce_n,
    output logic [NBANK-1:0]  ce_n
);
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        assign ce_n[i] = !(pass_en && (bank == BANK_W'(i)) && !host_ce_n);
    end
endmodule

// File: rtl/pfce_gate_ctrl.sv
`timescale 1ns/1ps
module pfce_gate_ctrl
    import pfce_pkg::*;
#(
    parameter int TWPT = 64,
    parameter int TCER = 15_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_fail_a,
    input  logic              host_ce_n,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [NBANK-1:0]  ce_n_out
);
    localparam int CW = cnt_width(TWPT, TCER);
    localparam logic [CW-1:0] WPT_LAST = CW'(TWPT - 1);
    localparam logic [CW-1:0] CER_LAST = CW'(TCER - 1);

    pfce_ctl_t   ctl_q, ctl_d;
    pfce_state_e state_q;
    logic        pf_s;
    logic [CW-1:0] cnt;
    logic        cnt_clr, cnt_inc, pass_en;
    logic [BANK_W-1:0] out_bank;

    assign state_q = ctl_q.st;

    pfce_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_async(pwr_fail_a), .q_sync(pf_s)
    );

    pfce_cyc_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_NORMAL: begin
                if (pf_s) ctl_d.st = (ctl_q.armed && !host_ce_n) ? ST_DRAIN : ST_PROTECT;
            end
            ST_DRAIN: begin
                if (host_ce_n || cnt == WPT_LAST) ctl_d.st = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (!pf_s) ctl_d.st = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (pf_s)                 ctl_d.st = ST_PROTECT;
                else if (cnt == CER_LAST) ctl_d.st = ST_NORMAL;
            end
            default: ctl_d.st = ST_RECOVER;
        endcase
        ctl_d.armed = (ctl_q.st == ST_NORMAL) && (ctl_d.st == ST_NORMAL)
                      && (ctl_q.armed || host_ce_n);
        if (ctl_q.st == ST_NORMAL) ctl_d.bank = bank_sel;
    end

    assign cnt_clr = (ctl_d.st != ctl_q.st);
    assign cnt_inc = (ctl_q.st == ST_DRAIN) || (ctl_q.st == ST_RECOVER);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st    <= ST_RECOVER;
            ctl_q.armed <= 1'b0;
            ctl_q.bank  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pass_en  = ((ctl_q.st == ST_NORMAL) && ctl_q.armed) || (ctl_q.st == ST_DRAIN);
    assign out_bank = (ctl_q.st == ST_DRAIN) ? ctl_q.bank : bank_sel;

    pfce_ce_decode u_dec (
        .pass_en(pass_en), .bank(out_bank), .host_ce_n(host_ce_n), .ce_n(ce_n_out)
    );
endmodule

// File: rtl/pfce_gate_ctrl_chk.sv
`timescale 1ns/1ps
module pfce_gate_ctrl_chk
    import pfce_pkg::*;
#(
    parameter int TWPT = 64,
    parameter int TCER = 15_000_000
) (
    input logic             clk,
    input logic             rst,
    input logic             host_ce_n,
    input logic [NBANK-1:0] ce_n_out,
    input pfce_state_e      state,
    input logic             pf_s
);
    int unsigned drain_run, rec_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            drain_run <= 0;
            rec_run   <= 0;
        end else begin
            drain_run <= (state == ST_DRAIN)   ? drain_run + 1 : 0;
            rec_run   <= (state == ST_RECOVER) ? rec_run + 1   : 0;
        end
    end

    // R2: never two banks enabled together
    p_one_bank_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ce_n_out));

    // R8, R1: protected or recovering means every bank disabled
    p_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROTECT || state == ST_RECOVER) |-> ce_n_out == '1);

    // R4: host ending the access closes the drain
    p_drain_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && host_ce_n) |=> state == ST_PROTECT);

    // R5: drain never outlasts the write-protect window
    p_drain_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> drain_run < TWPT);

    // R6: a returning fail aborts recovery
    p_recover_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER && pf_s) |=> state == ST_PROTECT);

    // R6: recovery window bounded by TCER
    p_recover_len_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RECOVER) |-> rec_run < TCER);

    // R7: first cycle back in normal passes nothing
    p_no_stale_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && $past(state) == ST_RECOVER) |-> ce_n_out == '1);
endmodule

bind pfce_gate_ctrl pfce_gate_ctrl_chk #(.TWPT(TWPT), .TCER(TCER)) u_chk (
    .clk(clk), .rst(rst), .host_ce_n(host_ce_n), .ce_n_out(ce_n_out),
    .state(state_q), .pf_s(pf_s)
);

// File: tb/pfce_gate_ctrl_bench.sv
`timescale 1ns/1ps
module pfce_gate_ctrl_bench;
    localparam int TWPT = 4;
    localparam int TCER = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_fail_a = 1'b0;
    logic       host_ce_n = 1'b1;
    logic [1:0] bank_sel = 2'd0;
    logic [3:0] ce_n_out;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    pfce_gate_ctrl #(.TWPT(TWPT), .TCER(TCER)) u_pfce_gate_ctrl (
        .clk(clk), .rst(rst), .pwr_fail_a(pwr_fail_a),
        .host_ce_n(host_ce_n), .bank_sel(bank_sel), .ce_n_out(ce_n_out)
    );

    function automatic logic [3:0] sel_low(input logic [1:0] b);
        return ~(4'b0001 << b);
    endfunction

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic check(input logic [3:0] exp, input string tag);
        #1;
        vectors++;
        if (ce_n_out !== exp) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b", tag, ce_n_out, exp);
        end
    endtask

    // drive a one-cycle access request, check, then release before the edge
    task automatic probe(input logic [3:0] exp, input string tag);
        host_ce_n = 1'b0;
        check(exp, tag);
        #1 host_ce_n = 1'b1;
    endtask

    task automatic settle_normal();
        host_ce_n = 1'b1;
        pwr_fail_a = 1'b0;
        repeat (TCER + 6) nedge();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) nedge();
        check(4'hF, "R1 in reset");
        rst = 1'b0;
        for (int k = 1; k <= TCER + 1; k++) begin
            nedge();
            probe((k <= TCER) ? 4'hF : sel_low(2'd0), "R1 reset window length");
        end
        // access held low through the whole window
        nedge(); rst = 1'b1; host_ce_n = 1'b0;
        nedge(); rst = 1'b0;
        for (int k = 1; k <= TCER + 3; k++) begin
            nedge();
            check(4'hF, "R7 held access not passed");
        end
        host_ce_n = 1'b1;
        nedge();
        probe(sel_low(2'd0), "R7 resumes after idle edge");
    endtask

    task automatic t_follow();
        for (int b = 0; b < 4; b++) begin
            nedge();
            bank_sel = 2'(b);
            check(4'hF, "R2 idle all high");
            probe(sel_low(2'(b)), "R2 selected bank follows");
        end
        bank_sel = 2'd0;
    endtask

    task automatic t_fail_idle();
        nedge();
        pwr_fail_a = 1'b1;
        nedge(); probe(sel_low(2'd0), "R3 sync latency edge1");
        nedge(); probe(sel_low(2'd0), "R3 sync latency edge2");
        nedge(); probe(4'hF, "R3 protected at edge3");
        for (int b = 0; b < 4; b++) begin
            nedge();
            bank_sel = 2'(b);
            host_ce_n = 1'b0;
            check(4'hF, "R8 host ignored while protected");
        end
        host_ce_n = 1'b1;
        bank_sel = 2'd0;
        nedge();
        pwr_fail_a = 1'b0;
        for (int k = 1; k <= TCER + 4; k++) begin
            nedge();
            probe((k <= TCER + 3) ? 4'hF : sel_low(2'd0), "R6 recovery length");
        end
    endtask

    task automatic t_drain_end();
        nedge();
        bank_sel = 2'd2;
        host_ce_n = 1'b0;
        pwr_fail_a = 1'b1;
        check(sel_low(2'd2), "R2 access on bank 2");
        nedge(); check(sel_low(2'd2), "R4 before fail takes effect");
        nedge(); check(sel_low(2'd2), "R4 before fail takes effect");
        nedge();
        bank_sel = 2'd1;
        check(sel_low(2'd2), "R4 drain keeps latched bank");
        nedge(); check(sel_low(2'd2), "R4 drain continues");
        host_ce_n = 1'b1;
        check(4'hF, "R4 host ends access");
        nedge();
        probe(4'hF, "R7 new access during protect");
        settle_normal();
        probe(sel_low(2'd1), "R4 normal again on bank 1");
    endtask

    task automatic t_drain_timeout();
        nedge();
        bank_sel = 2'd3;
        host_ce_n = 1'b0;
        pwr_fail_a = 1'b1;
        nedge(); check(sel_low(2'd3), "R5 pre-sync edge1");
        nedge(); check(sel_low(2'd3), "R5 pre-sync edge2");
        for (int k = 0; k < TWPT; k++) begin
            nedge();
            check(sel_low(2'd3), "R5 drain within window");
        end
        nedge(); check(4'hF, "R5 forced high at timeout");
        nedge(); check(4'hF, "R5 stays high while held");
        settle_normal();
        probe(sel_low(2'd3), "R5 normal again on bank 3");
        bank_sel = 2'd0;
    endtask

    task automatic t_recover_restart();
        nedge();
        pwr_fail_a = 1'b1;
        repeat (4) nedge();
        pwr_fail_a = 1'b0;
        for (int k = 0; k < 4; k++) begin
            nedge();
            probe(4'hF, "R6 partial recovery blocked");
        end
        pwr_fail_a = 1'b1;
        for (int k = 0; k < 4; k++) begin
            nedge();
            probe(4'hF, "R6 fail during recovery");
        end
        pwr_fail_a = 1'b0;
        for (int k = 1; k <= TCER + 4; k++) begin
            nedge();
            probe((k <= TCER + 3) ? 4'hF : sel_low(2'd0), "R6 restarted full window");
        end
    endtask

    initial begin
        t_reset();
        t_follow();
        t_fail_idle();
        t_drain_end();
        t_drain_timeout();
        t_recover_restart();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule